// File: doc/BRIEF.md
# Banked Configuration Register File

This block keeps a live set of sixteen byte-wide configuration registers next to a scratch store of eight banks. Each bank holds sixteen bytes, so the store holds 128 bytes. A controller reaches it through one request channel. Each request carries an operation code, a linear address, a bank number, an all-banks flag and a data byte. Single bytes move between the channel and either the registers or the store. The store is reached through a linear pointer that steps by one after every byte access. A whole set of settings can be saved from the registers into any bank, or restored from a bank into the registers. A modulo-256 sum over one bank or over the whole store lets the controller confirm that the stored contents are intact.

A linear store address splits into a bank number (upper three bits) and an offset (lower four bits). For example, 0x14 is bank 1, offset 4. The offset is the register index that the byte mirrors when the bank is copied. Apart from bank copies, the store is independent of the registers and can be used as plain storage.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a bank copy or a sum is running. A request presented while `req_ready` is low is dropped, not held, so the sender must wait for ready before it offers a request. The response side is a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take `rsp_data` in that cycle.

Top module: `cfg_bank_store`

## Requirements
- R1: After reset every register holds the parameter `REG_RST` (0x5A by default), every store byte is 0x00 and the pointer is 0. `busy` and `rsp_valid` are low and `req_ready` is high.
- R2: Op code 0 writes `req_data` to the register at index `req_addr[3:0]`. Op code 1 reads that register: `rsp_valid` is high with the byte in the cycle after the request is accepted.
- R3: Op code 2 loads the pointer from `req_addr`. Op code 4 returns the store byte at the pointer in the cycle after acceptance, then advances the pointer by one.
- R4: Op code 3 writes `req_data` to the store byte at the pointer, then advances the pointer. Stepping from offset 0xF of bank n lands on offset 0x0 of bank n+1.
- R5: A pointer step from address 0x7F (bank 7, offset 0xF) wraps to address 0x00.
- R6: Op code 5 copies registers 0..15 into store bank `req_bank`, one byte per clock. `busy` is high for exactly 16 cycles after acceptance.
- R7: Op code 6 copies store bank `req_bank` into registers 0..15, also for exactly 16 busy cycles.
- R8: Op code 7 with `req_all`=0 returns the 8-bit modulo-256 sum of the 16 bytes of bank `req_bank`. `busy` is high for 16 cycles, and the sum appears with `rsp_valid` in the cycle `busy` falls. A sum leaves the registers and the store unchanged.
- R9: Op code 7 with `req_all`=1 sums all 128 store bytes, with `busy` high for 128 cycles.
- R10: While `busy` is high, `req_ready` is low and any offered request has no effect.
- R11: Register writes never change the store, and copies and sums never move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_op | input | 3 | Operation code (see R2–R9) |
| req_addr | input | 7 | Register index (low 4 bits) or pointer value |
| req_bank | input | 3 | Bank for copy and sum |
| req_all | input | 1 | Sum over all banks |
| req_data | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Read byte or sum |
| busy | output | 1 | Copy or sum in progress |

## Verification
The bench uses the default parameters: 8-bit bytes, 16 registers, 8 banks and a register reset value of 0x5A. With these values, the bank boundary at 0x1F→0x20 and the end-of-store wrap at 0x7F→0x00 are reached in a handful of pointer accesses. A full-store sum takes 128 cycles, short enough to run alongside requests offered while busy. A sum of known bytes is driven past 255 to exercise the modulo-256 result, and a mid-run reset is applied to show that the store is cleared again.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [2:0] {
    OP_REG_WR  = 3'd0,
    OP_REG_RD  = 3'd1,
    OP_PTR_SET = 3'd2,
    OP_RAM_WR  = 3'd3,
    OP_RAM_RD  = 3'd4,
    OP_SAVE    = 3'd5,
    OP_LOAD    = 3'd6,
    OP_CSUM    = 3'd7
  } cfgb_op_e;
endpackage

// File: rtl/cfgb_regs.sv
module cfgb_regs #(
  parameter int DW = 8,
  parameter int N = 16,
  parameter logic [DW-1:0] RST_VAL = '0,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= RST_VAL;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R2: a written byte is present at its index on the next cycle
  assert_reg_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cfgb_ram.sv
module cfgb_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R4: a store write lands at its address on the next cycle
  assert_ram_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int DW = 8,
  parameter int N_REGS = 16,
  parameter int N_BANKS = 8,
  localparam int OW = $clog2(N_REGS),
  localparam int BW = $clog2(N_BANKS),
  localparam int AW = OW + BW,
  localparam int DEPTH = N_REGS * N_BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_bank,
  input  logic          req_all,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          reg_we,
  output logic [OW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata,
  output logic [OW-1:0] reg_raddr,
  input  logic [DW-1:0] reg_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_rdata
);
  cfgb_op_e      op;
  cfgb_op_e      job_q;
  logic          busy_q;
  logic          accept;
  logic          is_job;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_next;
  logic [AW-1:0] base_q;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] job_addr;
  logic [DW-1:0] acc_q;
  logic          job_end;

  assign op        = cfgb_op_e'(req_op);
  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign is_job    = (op == OP_SAVE) || (op == OP_LOAD) || (op == OP_CSUM);
  assign job_addr  = base_q + cnt_q;
  assign job_end   = busy_q && (cnt_q == last_q);
  assign ptr_next  = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign reg_raddr = busy_q ? cnt_q[OW-1:0] : req_addr[OW-1:0];
  assign ram_raddr = busy_q ? job_addr : ptr_q;

  always_comb begin
    reg_we    = 1'b0;
    reg_waddr = req_addr[OW-1:0];
    reg_wdata = req_data;
    ram_we    = 1'b0;
    ram_waddr = ptr_q;
    ram_wdata = req_data;
    if (busy_q) begin
      if (job_q == OP_SAVE) begin
        ram_we    = 1'b1;
        ram_waddr = job_addr;
        ram_wdata = reg_rdata;
      end else if (job_q == OP_LOAD) begin
        reg_we    = 1'b1;
        reg_waddr = cnt_q[OW-1:0];
        reg_wdata = ram_rdata;
      end
    end else if (accept) begin
      if (op == OP_REG_WR) reg_we = 1'b1;
      if (op == OP_RAM_WR) ram_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      job_q     <= OP_REG_WR;
      ptr_q     <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      last_q    <= '0;
      acc_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (job_q == OP_CSUM) acc_q <= acc_q + ram_rdata;
        if (job_end) begin
          busy_q <= 1'b0;
          if (job_q == OP_CSUM) begin
            rsp_valid <= 1'b1;
            rsp_data  <= acc_q + ram_rdata;
          end
        end
      end else if (accept) begin
        case (op)
          OP_REG_RD: begin
            rsp_valid <= 1'b1;
            rsp_data  <= reg_rdata;
          end
          OP_PTR_SET: ptr_q <= req_addr;
          OP_RAM_WR:  ptr_q <= ptr_next;
          OP_RAM_RD: begin
            rsp_valid <= 1'b1;
            rsp_data  <= ram_rdata;
            ptr_q     <= ptr_next;
          end
          default: ;
        endcase
        if (is_job) begin
          busy_q <= 1'b1;
          job_q  <= op;
          cnt_q  <= '0;
          acc_q  <= '0;
          if (op == OP_CSUM && req_all) begin
            base_q <= '0;
            last_q <= AW'(DEPTH - 1);
          end else begin
            base_q <= {req_bank, OW'(0)};
            last_q <= AW'(N_REGS - 1);
          end
        end
      end
    end
  end

  // R3: a response only follows an accepted read or the end of a job
  assert_rsp_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy_q) || $past(accept && (op == OP_REG_RD || op == OP_RAM_RD)));

  // R5: a store access at the top address wraps the pointer to zero
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_RAM_WR || op == OP_RAM_RD) && ptr_q == AW'(DEPTH - 1)) |=> ptr_q == '0);

  // R8: a sum writes neither the registers nor the store
  assert_csum_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && job_q == OP_CSUM) |-> !reg_we && !ram_we);

  // R11: the pointer does not move while a job runs
  assert_ptr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(ptr_q));

  // R10: a job that reaches its last byte releases the channel
  assert_job_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    job_end |=> req_ready);
endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store #(
  parameter int DATA_W = 8,
  parameter int N_REGS = 16,
  parameter int N_BANKS = 8,
  parameter logic [DATA_W-1:0] REG_RST = 8'h5A
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [2:0]                            req_op,
  input  logic [$clog2(N_REGS*N_BANKS)-1:0]     req_addr,
  input  logic [$clog2(N_BANKS)-1:0]            req_bank,
  input  logic                                  req_all,
  input  logic [DATA_W-1:0]                     req_data,
  output logic                                  rsp_valid,
  output logic [DATA_W-1:0]                     rsp_data,
  output logic                                  busy
);
  localparam int OW = $clog2(N_REGS);
  localparam int DEPTH = N_REGS * N_BANKS;
  localparam int AW = $clog2(DEPTH);

  logic              reg_we;
  logic [OW-1:0]     reg_waddr;
  logic [DATA_W-1:0] reg_wdata;
  logic [OW-1:0]     reg_raddr;
  logic [DATA_W-1:0] reg_rdata;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [AW-1:0]     ram_raddr;
  logic [DATA_W-1:0] ram_rdata;

  cfgb_ctrl #(.DW(DATA_W), .N_REGS(N_REGS), .N_BANKS(N_BANKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_bank(req_bank), .req_all(req_all), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );

  cfgb_regs #(.DW(DATA_W), .N(N_REGS), .RST_VAL(REG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata)
  );

  cfgb_ram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: tb/cfg_bank_store_tb.sv
module cfg_bank_store_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_RWR = 3'd0, C_RRD = 3'd1, C_PSET = 3'd2, C_MWR = 3'd3,
                         C_MRD = 3'd4, C_SAVE = 3'd5, C_LOAD = 3'd6, C_SUM = 3'd7;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] op;
    logic [6:0] addr;
    logic [2:0] bank;
    logic       all;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  C_RWR,  7'h03, 3'd0, 1'b0, 8'h11, 8'h00}, // R2
    '{4'd2,  C_RWR,  7'h0F, 3'd0, 1'b0, 8'hF0, 8'h00}, // R2
    '{4'd2,  C_RRD,  7'h03, 3'd0, 1'b0, 8'h00, 8'h11}, // R2
    '{4'd2,  C_RRD,  7'h0F, 3'd0, 1'b0, 8'h00, 8'hF0}, // R2
    '{4'd1,  C_RRD,  7'h07, 3'd0, 1'b0, 8'h00, 8'h5A}, // R1 default
    '{4'd3,  C_PSET, 7'h1E, 3'd0, 1'b0, 8'h00, 8'h00}, // R3
    '{4'd4,  C_MWR,  7'h00, 3'd0, 1'b0, 8'h21, 8'h00}, // R4 0x1E
    '{4'd4,  C_MWR,  7'h00, 3'd0, 1'b0, 8'h22, 8'h00}, // R4 0x1F
    '{4'd4,  C_MWR,  7'h00, 3'd0, 1'b0, 8'h23, 8'h00}, // R4 0x20
    '{4'd3,  C_PSET, 7'h1F, 3'd0, 1'b0, 8'h00, 8'h00}, // R3
    '{4'd3,  C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'h22}, // R3
    '{4'd4,  C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'h23}, // R4 bank crossing
    '{4'd5,  C_PSET, 7'h7F, 3'd0, 1'b0, 8'h00, 8'h00}, // R5
    '{4'd5,  C_MWR,  7'h00, 3'd0, 1'b0, 8'hF7, 8'h00}, // R5 0x7F
    '{4'd5,  C_MWR,  7'h00, 3'd0, 1'b0, 8'h01, 8'h00}, // R5 wrapped to 0x00
    '{4'd5,  C_PSET, 7'h7F, 3'd0, 1'b0, 8'h00, 8'h00}, // R5
    '{4'd5,  C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'hF7}, // R5
    '{4'd5,  C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'h01}, // R5
    '{4'd8,  C_SUM,  7'h00, 3'd1, 1'b0, 8'h00, 8'h43}, // R8 bank 1
    '{4'd8,  C_SUM,  7'h00, 3'd2, 1'b0, 8'h00, 8'h23}, // R8 bank 2
    '{4'd9,  C_SUM,  7'h00, 3'd0, 1'b1, 8'h00, 8'h5E}, // R9 all, 350 mod 256
    '{4'd6,  C_SAVE, 7'h00, 3'd6, 1'b0, 8'h00, 8'h00}, // R6
    '{4'd6,  C_SUM,  7'h00, 3'd6, 1'b0, 8'h00, 8'hED}, // R6 saved bank sum
    '{4'd11, C_RWR,  7'h03, 3'd0, 1'b0, 8'h00, 8'h00}, // R11
    '{4'd7,  C_LOAD, 7'h00, 3'd1, 1'b0, 8'h00, 8'h00}, // R7
    '{4'd7,  C_RRD,  7'h0E, 3'd0, 1'b0, 8'h00, 8'h21}, // R7
    '{4'd7,  C_RRD,  7'h03, 3'd0, 1'b0, 8'h00, 8'h00}, // R7
    '{4'd7,  C_RRD,  7'h0F, 3'd0, 1'b0, 8'h00, 8'h22}, // R7
    '{4'd11, C_PSET, 7'h63, 3'd0, 1'b0, 8'h00, 8'h00}, // R11
    '{4'd11, C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'h11}, // R11 reg write left store alone
    '{4'd11, C_PSET, 7'h60, 3'd0, 1'b0, 8'h00, 8'h00}, // R11
    '{4'd11, C_SUM,  7'h00, 3'd0, 1'b0, 8'h00, 8'h01}, // R11 sum bank 0
    '{4'd11, C_MRD,  7'h00, 3'd0, 1'b0, 8'h00, 8'h5A}  // R11 pointer still 0x60
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = '0;
  logic [6:0] req_addr = '0;
  logic [2:0] req_bank = '0;
  logic       req_all = 1'b0;
  logic [7:0] req_data = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       busy;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_bank_store u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_bank(req_bank), .req_all(req_all),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy)
  );

  task automatic check(input bit ok, input int r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [6:0] a, input logic [2:0] b,
                      input logic al, input logic [7:0] d);
    @(negedge clk);
    req_op = op; req_addr = a; req_bank = b; req_all = al; req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_job(output int n, output logic got, output logic [7:0] d);
    n = 0; got = 1'b0; d = '0;
    while (busy) begin
      n++;
      @(negedge clk);
      if (rsp_valid) begin got = 1'b1; d = rsp_data; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic got;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(!busy && req_ready && !rsp_valid, 1, "reset flags",
          {busy, req_ready, rsp_valid}, 3'b010);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      send(v.op, v.addr, v.bank, v.all, v.data);
      if (v.op == C_RRD || v.op == C_MRD) begin
        check(rsp_valid && rsp_data == v.exp, int'(v.req), "read byte",
              {rsp_valid, rsp_data}, {1'b1, v.exp});
      end else if (v.op == C_SAVE || v.op == C_LOAD || v.op == C_SUM) begin
        wait_job(n, got, d);
        check(n == (v.all ? 128 : 16), int'(v.req), "busy cycles", n, v.all ? 128 : 16);
        if (v.op == C_SUM)
          check(got && d == v.exp, int'(v.req), "sum", {got, d}, {1'b1, v.exp});
      end else begin
        check(!rsp_valid, int'(v.req), "no response on write", rsp_valid, 0);
      end
    end

    // R10: requests offered while busy are dropped
    @(negedge clk);
    req_op = C_SUM; req_all = 1'b1; req_bank = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_op = C_RWR; req_addr = 7'h00; req_data = 8'hEE; req_all = 1'b0;
    check(!req_ready && busy, 10, "ready while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    req_op = C_PSET; req_addr = 7'h05;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_job(n, got, d);
    // store: 01,21,22,23,F7 + saved bank 6 (sum ED) -> 0x5E+0xED = 0x4B
    check(got && d == 8'h4B, 9, "all-bank sum after save", {got, d}, 9'h14B);
    send(C_RRD, 7'h00, 3'd0, 1'b0, 8'h00);
    check(rsp_valid && rsp_data == 8'h00, 10, "reg0 untouched", rsp_data, 8'h00);
    send(C_MRD, 7'h00, 3'd0, 1'b0, 8'h00); // pointer still 0x61 -> saved reg1 = 5A
    check(rsp_valid && rsp_data == 8'h5A, 10, "pointer untouched", rsp_data, 8'h5A);

    // R1: reset in mid-use restores defaults and clears the store
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(!busy && req_ready && !rsp_valid, 1, "flags after reset",
          {busy, req_ready, rsp_valid}, 3'b010);
    send(C_RRD, 7'h0F, 3'd0, 1'b0, 8'h00);
    check(rsp_valid && rsp_data == 8'h5A, 1, "reg15 default", rsp_data, 8'h5A);
    send(C_MRD, 7'h00, 3'd0, 1'b0, 8'h00);
    check(rsp_valid && rsp_data == 8'h00, 1, "store byte 0 cleared", rsp_data, 8'h00);
    send(C_SUM, 7'h00, 3'd0, 1'b1, 8'h00);
    wait_job(n, got, d);
    check(got && d == 8'h00 && n == 128, 1, "store sum cleared", {got, d}, 9'h100);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule